// File: doc/BRIEF.md
# Buffered Asynchronous Serial Port

This block is a memory-mapped asynchronous serial port for a 16-bit register bus. Sixteen-entry FIFOs sit on both the transmit and the receive side. Characters are framed as one start bit, eight data bits sent least significant bit first, and one stop bit, with no parity. Software fills the transmit FIFO through a data port and drains the receive FIFO through another port. It watches progress through sticky status flags, a line-status register and an occupancy register.

The bit time is set by an 8-bit divisor N: one bit lasts 32·(N+1) clocks. The transmitter is a four-state machine. TX_IDLE moves to TX_START when the transmitter is enabled and the FIFO holds data, popping one entry. TX_START moves to TX_DATA after one bit time. TX_DATA moves to TX_STOP after the eighth data bit. TX_STOP returns to TX_IDLE after one bit time and pulses a completion strobe.

The receiver is a five-state machine. RX_IDLE moves to RX_START on a low line while the receiver is enabled. RX_START returns to RX_IDLE if the line is high again at half a bit time, and otherwise moves to RX_DATA. RX_DATA samples eight bits, one full bit time apart, and then moves to RX_STOP. RX_STOP stores the character after one bit time. It returns to RX_IDLE if the stop bit is high. If the stop bit is low it moves to RX_HOLD, and RX_HOLD returns to RX_IDLE once the line is high again.

Flags are cleared by a two-step handshake. Software must first read a flag as one and then write zero to it. A read and a later write of zero are both needed, so a stale write cannot wipe an event that software has not yet seen.

Top module: `sci_fifo_uart`

## Requirements
- R1: After reset, the status register (0x10) reads 0x0040, with only the transmit-end flag in bit 6 set. The line-status register (0x24) and the count register (0x1C) read 0, `txd` is 1 and `irq` is 0.
- R2: The transmitter is enabled by control bit 5 (register 0x08). A byte written to 0x0C appears on `txd` as a low start bit, eight data bits sent least significant bit first, and a high stop bit. Each bit lasts 32·(N+1) clocks, where N is the value in register 0x04.
- R3: The receiver is enabled by control bit 4. It samples each bit at its midpoint, and it drops a start bit that is high again at half a bit time. Each received character goes into the receive FIFO. The FIFO occupancy reads in bits 4:0 of register 0x1C.
- R4: A read of 0x14 returns the oldest received character and removes it from the FIFO. A read of 0x14 while the FIFO is empty returns the last character read and changes nothing.
- R5: The transmit FIFO holds 16 entries, and a write to it while it is full is dropped. The transmit FIFO occupancy reads in bits 12:8 of register 0x1C.
- R6: A character that arrives while the receive FIFO holds 16 entries is discarded, and it sets the overrun flag in bit 0 of register 0x24.
- R7: A low stop bit sets the framing-error flag (status bit 3) and the receive-error flag (status bit 7). If the data bits are also all zero, it sets the break flag (status bit 4).
- R8: Transmit end (status bit 6) sets when a stop bit finishes and the transmit FIFO is empty.
- R9: Writing 0 to a status bit or to line-status bit 0 clears the flag only if the flag has been read as 1 since it was set. Writing 1 leaves the flag unchanged.
- R10: While bit 1 of FIFO control (0x18) is set, the receive FIFO is held empty. While bit 2 is set, the transmit FIFO is held empty. The register reads back as written.
- R11: Status bit 0 (data ready) sets each time a character is stored. Status bit 1 sets whenever the receive FIFO holds 4 or more entries.
- R12: `irq` is high whenever any of status bits 0, 1, 3, 4 or 7 or the overrun flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 6 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of 0x14 pops the receive FIFO |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid in the cycle of the read |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line, idle high |
| irq | output | 1 | Level interrupt request |

## Verification
Some checks run on every cycle. These cover the FIFO occupancy bounds, a full FIFO dropping a push, the overrun flag following a rejected character, and a flag surviving a write of zero that was never armed by a read. They also cover transmit end following a completed frame with an empty FIFO, break implying a framing error, and the transmitter never popping an empty FIFO. Other behaviour can only be shown by the bench's scenarios. These are the exact bit timing for a given divisor and the rejection of a glitched start bit. They also include the ordering of receive data against a behavioural queue, the empty-read return value, and the FIFO reset bits.

// File: rtl/sci_pkg.sv
package sci_pkg;
    localparam logic [5:0] OFS_MODE = 6'h00;
    localparam logic [5:0] OFS_DIV  = 6'h04;
    localparam logic [5:0] OFS_CTRL = 6'h08;
    localparam logic [5:0] OFS_TXD  = 6'h0C;
    localparam logic [5:0] OFS_STAT = 6'h10;
    localparam logic [5:0] OFS_RXD  = 6'h14;
    localparam logic [5:0] OFS_FCTL = 6'h18;
    localparam logic [5:0] OFS_CNT  = 6'h1C;
    localparam logic [5:0] OFS_PORT = 6'h20;
    localparam logic [5:0] OFS_LINE = 6'h24;

    localparam int CTRL_RXEN  = 4;
    localparam int CTRL_TXEN  = 5;
    localparam int FCTL_RXCLR = 1;
    localparam int FCTL_TXCLR = 2;

    localparam int ST_DR   = 0;
    localparam int ST_RDF  = 1;
    localparam int ST_FER  = 3;
    localparam int ST_BRK  = 4;
    localparam int ST_TEND = 6;
    localparam int ST_ER   = 7;
    localparam logic [7:0] ST_MASK = 8'hDB;
    localparam logic [7:0] ST_IRQ  = 8'h9B;

    localparam int TIMER_W = 14;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD} rx_state_t;
endpackage

// File: rtl/sci_fifo.sv
module sci_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CW-1:0]    count,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign rdata   = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (count == CW'(DEPTH)));
endmodule

// File: rtl/sci_tx.sv
module sci_tx
    import sci_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [7:0] div,
    input  logic       have_data,
    input  logic [7:0] data,
    output logic       pop_o,
    output logic       done_o,
    output logic       txd
);
    tx_state_t          state_q, state_d;
    logic [TIMER_W-1:0] cnt_q, bit_len;
    logic [2:0]         idx_q;
    logic [7:0]         sh_q;
    logic               bit_last;

    assign bit_len  = (TIMER_W'(div) + 1'b1) << 5;
    assign bit_last = (cnt_q == bit_len - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (en && have_data) state_d = TX_START;
            TX_START: if (bit_last) state_d = TX_DATA;
            TX_DATA:  if (bit_last && idx_q == 3'd7) state_d = TX_STOP;
            TX_STOP:  if (bit_last) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        pop_o  = (state_q == TX_IDLE) && en && have_data;
        done_o = (state_q == TX_STOP) && bit_last;
        unique case (state_q)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh_q[0];
            default:  txd = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
            sh_q  <= '0;
        end else begin
            cnt_q <= (state_q == TX_IDLE || bit_last) ? '0 : cnt_q + 1'b1;
            if (pop_o) sh_q <= data;
            if (state_q == TX_START) idx_q <= '0;
            if (state_q == TX_DATA && bit_last) begin
                sh_q  <= {1'b0, sh_q[7:1]};
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assert_no_empty_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pop_o |-> have_data);
    assert_stop_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> txd);
endmodule

// File: rtl/sci_rx.sv
module sci_rx
    import sci_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [7:0] div,
    input  logic       rxd,
    output logic       push_o,
    output logic [7:0] data_o,
    output logic       ferr_o,
    output logic       brk_o
);
    rx_state_t          state_q, state_d;
    logic [TIMER_W-1:0] cnt_q, bit_len, half_len;
    logic [2:0]         idx_q;
    logic [7:0]         sh_q;
    logic               meta_q, rx_s, bit_last, half_hit, restart;

    assign bit_len  = (TIMER_W'(div) + 1'b1) << 5;
    assign half_len = bit_len >> 1;
    assign bit_last = (cnt_q == bit_len - 1'b1);
    assign half_hit = (cnt_q == half_len - 1'b1);
    assign data_o   = sh_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            rx_s   <= 1'b1;
        end else begin
            meta_q <= rxd;
            rx_s   <= meta_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  if (en && !rx_s) state_d = RX_START;
            RX_START: if (half_hit) state_d = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (bit_last && idx_q == 3'd7) state_d = RX_STOP;
            RX_STOP:  if (bit_last) state_d = rx_s ? RX_IDLE : RX_HOLD;
            RX_HOLD:  if (rx_s) state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
    end

    always_comb begin
        push_o = (state_q == RX_STOP) && bit_last;
        ferr_o = push_o && !rx_s;
        brk_o  = ferr_o && (sh_q == 8'h00);
    end

    assign restart = (state_d != state_q) || bit_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            idx_q <= '0;
            sh_q  <= '0;
        end else begin
            cnt_q <= restart ? '0 : cnt_q + 1'b1;
            if (state_q == RX_START) idx_q <= '0;
            if (state_q == RX_DATA && bit_last) begin
                sh_q  <= {rx_s, sh_q[7:1]};
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assert_brk_has_ferr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_o |-> (ferr_o && push_o));
endmodule

// File: rtl/sci_fifo_uart.sv
module sci_fifo_uart
    import sci_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int RX_TRIGGER = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    input  logic        rxd,
    output logic        txd,
    output logic        irq
);
    localparam int CW = $clog2(FIFO_DEPTH + 1);

    logic [15:0]   mode_q, ctrl_q, fctl_q;
    logic [7:0]    div_q, last_q;
    logic [7:0]    stat_q, armed_q, stat_d, set_vec, clr_vec;
    logic          ovr_q, ovr_armed_q, ovr_d, ovr_clr;
    logic          tx_pop, tx_done, tx_full, tx_empty;
    logic [7:0]    tx_head, rx_head, rx_data;
    logic [CW-1:0] tx_cnt, rx_cnt;
    logic          rx_push, rx_ferr, rx_brk, rx_full, rx_empty, rx_pop;
    logic          wr_stat, rd_stat, wr_line, rd_line;

    assign wr_stat = bus_wr && bus_addr == OFS_STAT;
    assign rd_stat = bus_rd && bus_addr == OFS_STAT;
    assign wr_line = bus_wr && bus_addr == OFS_LINE;
    assign rd_line = bus_rd && bus_addr == OFS_LINE;
    assign rx_pop  = bus_rd && bus_addr == OFS_RXD && !rx_empty;

    sci_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(fctl_q[FCTL_TXCLR]),
        .push(bus_wr && bus_addr == OFS_TXD), .wdata(bus_wdata[7:0]),
        .pop(tx_pop), .rdata(tx_head), .count(tx_cnt),
        .full(tx_full), .empty(tx_empty));

    sci_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(fctl_q[FCTL_RXCLR]),
        .push(rx_push), .wdata(rx_data),
        .pop(rx_pop), .rdata(rx_head), .count(rx_cnt),
        .full(rx_full), .empty(rx_empty));

    sci_tx u_tx (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q[CTRL_TXEN]), .div(div_q),
        .have_data(!tx_empty), .data(tx_head), .pop_o(tx_pop),
        .done_o(tx_done), .txd(txd));

    sci_rx u_rx (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q[CTRL_RXEN]), .div(div_q),
        .rxd(rxd), .push_o(rx_push), .data_o(rx_data),
        .ferr_o(rx_ferr), .brk_o(rx_brk));

    // Flag sources and the read-one-then-write-zero clear handshake
    always_comb begin
        set_vec          = '0;
        set_vec[ST_DR]   = rx_push && !rx_full && !fctl_q[FCTL_RXCLR];
        set_vec[ST_RDF]  = rx_cnt >= CW'(RX_TRIGGER);
        set_vec[ST_FER]  = rx_ferr;
        set_vec[ST_BRK]  = rx_brk;
        set_vec[ST_TEND] = tx_done && tx_empty;
        set_vec[ST_ER]   = rx_ferr;
        clr_vec = wr_stat ? (~bus_wdata[7:0] & armed_q) : '0;
        stat_d  = ((stat_q & ~clr_vec) | set_vec) & ST_MASK;
        ovr_clr = wr_line && !bus_wdata[0] && ovr_armed_q;
        ovr_d   = (ovr_q && !ovr_clr) || (rx_push && rx_full);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q      <= 8'h40;
            armed_q     <= '0;
            ovr_q       <= 1'b0;
            ovr_armed_q <= 1'b0;
        end else begin
            stat_q      <= stat_d;
            armed_q     <= (armed_q | (rd_stat ? stat_q : 8'h00)) & ~clr_vec & stat_d;
            ovr_q       <= ovr_d;
            ovr_armed_q <= (ovr_armed_q || (rd_line && ovr_q)) && !ovr_clr && ovr_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            div_q  <= '0;
            ctrl_q <= '0;
            fctl_q <= '0;
            last_q <= '0;
        end else begin
            if (bus_wr) begin
                unique case (bus_addr)
                    OFS_MODE: mode_q <= bus_wdata;
                    OFS_DIV:  div_q  <= bus_wdata[7:0];
                    OFS_CTRL: ctrl_q <= bus_wdata;
                    OFS_FCTL: fctl_q <= bus_wdata;
                    default:  ;
                endcase
            end
            if (rx_pop) last_q <= rx_head;
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_MODE: bus_rdata = mode_q;
            OFS_DIV:  bus_rdata = {8'h00, div_q};
            OFS_CTRL: bus_rdata = ctrl_q;
            OFS_STAT: bus_rdata = {8'h00, stat_q};
            OFS_RXD:  bus_rdata = {8'h00, rx_empty ? last_q : rx_head};
            OFS_FCTL: bus_rdata = fctl_q;
            OFS_CNT:  bus_rdata = (16'(tx_cnt) << 8) | 16'(rx_cnt);
            OFS_PORT: bus_rdata = {14'h0000, txd, rxd};
            OFS_LINE: bus_rdata = {15'h0000, ovr_q};
            default:  bus_rdata = 16'h0000;
        endcase
    end

    assign irq = (|(stat_q & ST_IRQ)) || ovr_q;

    assert_overrun_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> ovr_q);
    assert_unarmed_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && stat_q[ST_DR] && !armed_q[ST_DR]) |=> stat_q[ST_DR]);
    assert_tend_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_done && tx_empty) |=> stat_q[ST_TEND]);
endmodule

// File: tb/sci_fifo_uart_bench.sv
module sci_fifo_uart_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        rxd = 1'b1;
    logic        txd, irq;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;
    logic [7:0] rx_model[$];
    bit rx_en_model = 0;

    always #2.5 clk = ~clk;

    sci_fifo_uart u_sci_fifo_uart (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd), .irq(irq));

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
        if (a == 6'h14 && rx_model.size() > 0) void'(rx_model.pop_front());
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop_bit);
        logic [9:0] frame;
        frame = {stop_bit, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            rxd = frame[i];
            repeat (31) @(negedge clk);
        end
        @(negedge clk);
        rxd = 1'b1;
        repeat (8) @(negedge clk);
        if (rx_en_model && rx_model.size() < 16) rx_model.push_back(b);
    endtask

    task automatic cap_tx(input int bit_clks, output logic [7:0] b);
        while (txd === 1'b1) @(negedge clk);
        repeat (bit_clks / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (bit_clks) @(negedge clk);
            b[i] = txd;
        end
        repeat (bit_clks) @(negedge clk);
    endtask

    task automatic clear_flags();
        logic [15:0] d;
        rd(6'h10, d); wr(6'h10, 16'h0000);
        rd(6'h24, d); wr(6'h24, 16'h0000);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [7:0]  b;
        int          lows;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd(6'h10, d); chk("R1 status", d, 16'h0040);
        rd(6'h24, d); chk("R1 line", d, 0);
        rd(6'h1C, d); chk("R1 count", d, 0);
        chk("R1 txd", txd, 1);
        chk("R1 irq", irq, 0);

        // R2 framing and timing
        wr(6'h08, 16'h0030); rx_en_model = 1;
        fork
            wr(6'h0C, 16'h005A);
            cap_tx(32, b);
        join
        chk("R2 byte 5A", b, 8'h5A);
        wr(6'h04, 16'h0001);
        fork
            wr(6'h0C, 16'h0001);
            begin
                while (txd === 1'b1) @(negedge clk);
                lows = 0;
                while (txd === 1'b0) begin lows++; @(negedge clk); end
            end
        join
        chk("R2 start bit clocks N=1", lows, 64);
        repeat (700) @(negedge clk);
        wr(6'h04, 16'h0000);

        // R3/R4 receive, pop, empty read
        send_rx(8'hA5, 1'b1);
        rd(6'h1C, d); chk("R3 rx count", d[4:0], rx_model.size());
        rd(6'h10, d); chk("R11 data ready", d[0], 1);
        rd(6'h14, d); chk("R4 pop value", d[7:0], 8'hA5);
        rd(6'h1C, d); chk("R4 count after pop", d[4:0], 0);
        rd(6'h14, d); chk("R4 empty read value", d[7:0], 8'hA5);
        rd(6'h1C, d); chk("R4 empty read count", d[4:0], 0);

        // R3 glitched start bit and disabled receiver
        @(negedge clk); rxd = 1'b0;
        repeat (8) @(negedge clk); rxd = 1'b1;
        repeat (400) @(negedge clk);
        rd(6'h1C, d); chk("R3 glitch ignored", d[4:0], 0);
        wr(6'h08, 16'h0020); rx_en_model = 0;
        send_rx(8'h11, 1'b1);
        rd(6'h1C, d); chk("R3 rx disabled", d[4:0], 0);
        wr(6'h08, 16'h0030); rx_en_model = 1;

        // R9 clear handshake, R12 irq
        clear_flags();
        rd(6'h10, d); chk("R9 all cleared", d, 0);
        chk("R12 irq low", irq, 0);
        send_rx(8'h33, 1'b1);
        chk("R12 irq on ready", irq, 1);
        wr(6'h10, 16'h0000);
        rd(6'h10, d); chk("R9 unarmed write kept", d[0], 1);
        wr(6'h10, 16'h00FF);
        rd(6'h10, d); chk("R9 write one kept", d[0], 1);
        wr(6'h10, 16'h0000);
        rd(6'h10, d); chk("R9 armed clear", d[0], 0);
        chk("R12 irq after clear", irq, 0);
        rd(6'h14, d); chk("R4 fifo order", d[7:0], 8'h33);

        // R11 trigger level
        for (int i = 0; i < 4; i++) send_rx(8'(8'h10 + i), 1'b1);
        rd(6'h10, d); chk("R11 trigger flag", d[1], 1);
        for (int i = 0; i < 4; i++) begin
            b = rx_model[0];
            rd(6'h14, d); chk("R3 order vs model", d[7:0], b);
        end

        // R7 framing and break
        clear_flags();
        send_rx(8'h3C, 1'b0);
        rd(6'h10, d); chk("R7 framing flags", d[7:0] & 8'h98, 8'h88);
        send_rx(8'h00, 1'b0);
        rd(6'h10, d); chk("R7 break flag", d[4], 1);

        // R10 receive FIFO reset
        wr(6'h18, 16'h0002);
        rd(6'h18, d); chk("R10 readback", d, 16'h0002);
        rd(6'h1C, d); chk("R10 rx cleared", d[4:0], 0);
        wr(6'h18, 16'h0000); rx_model.delete();

        // R6 overrun
        clear_flags();
        for (int i = 0; i < 16; i++) send_rx(8'(i * 7 + 1), 1'b1);
        rd(6'h24, d); chk("R6 no overrun at 16", d[0], 0);
        send_rx(8'hEE, 1'b1);
        rd(6'h24, d); chk("R6 overrun set", d[0], 1);
        rd(6'h1C, d); chk("R6 count stays 16", d[4:0], 16);
        rd(6'h14, d); chk("R6 oldest kept", d[7:0], 8'h01);
        wr(6'h18, 16'h0002); wr(6'h18, 16'h0000); rx_model.delete();

        // R5 transmit FIFO depth, R10 transmit reset
        wr(6'h08, 16'h0010);
        for (int i = 0; i < 17; i++) wr(6'h0C, 16'(i));
        rd(6'h1C, d); chk("R5 tx count capped", d[12:8], 16);
        wr(6'h18, 16'h0004);
        rd(6'h1C, d); chk("R10 tx cleared", d[12:8], 0);
        wr(6'h18, 16'h0000);

        // R8 transmit end
        clear_flags();
        rd(6'h10, d); chk("R8 tend cleared", d[6], 0);
        wr(6'h08, 16'h0030);
        fork
            wr(6'h0C, 16'h0042);
            cap_tx(32, b);
        join
        chk("R2 byte 42", b, 8'h42);
        repeat (40) @(negedge clk);
        rd(6'h10, d); chk("R8 tend set", d[6], 1);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule